// File: doc/BRIEF.md
# Core Execution Status Controller

This block is the control state machine for a single-issue processor core. It decides, cycle by cycle, whether the core may advance, and it tracks seven conditions: idle, running, stalled on an instruction-fetch miss, resuming after that miss, stalled on a data-access miss, waiting for a data miss to drain before a hand-off, and handed off to another core. Instruction execution, the caches and address translation sit outside the block. They appear only as per-lane miss flags that come back during the cycle the block grants a tick, and as a single completion pulse when an outstanding miss is filled.

Each cycle offers up to `LANES` ticks. The lanes are granted in order, and the grant stops after the first lane that reports a miss, so the core stops early once it leaves the running condition. Activate, suspend and hand-off requests are single-cycle pulses. A request that the current condition does not allow raises a sticky error flag and leaves the state as it was. The block counts the cycles spent waiting on each cache in two saturating counters.

Top module: `core_exec_ctrl`

## Requirements
- R1: After synchronous active-high reset, `exec_state` is 0 (idle), `tick_en` is all zero, `swout_ack`, `replay_ld` and `ctrl_err` are 0, and both stall counters are 0.
- R2: An activate pulse while idle (0) or handed off (6) moves to running (1) at the next edge. Running grants ticks starting in the first cycle in which `exec_state` reads 1.
- R3: A suspend pulse while running (1) or handed off (6) moves to idle (0) at the next edge, and no lane is granted in the cycle of the request.
- R4: `ctrl_err` rises at the next edge and then stays high until reset, and the state is left unchanged, whenever a cycle holds one of these: an activate outside states 0 and 6; a suspend outside states 1 and 6; two or more of the pulses activate, suspend, hand-off and completion. No lane is granted in any cycle that carries a request or a completion pulse.
- R5: In state 1 or 3 with no pulse present, lane i is granted exactly when no lane below i reported a miss. The lane that reports a miss is itself granted.
- R6: A fetch miss in a granted lane moves to state 2. A fetch miss takes priority over a data miss in the same lane. A completion pulse in state 2 moves to state 3. In state 3, `resume_no_fetch` is high and the fetch-miss flag of lane 0 is ignored. If no lane misses, state 3 moves to 1 after one cycle.
- R7: A data miss in a granted lane, with no fetch miss in that lane, moves to state 4. The completion pulse in state 4 moves to state 1 and drives `replay_ld` high in that same cycle only if the missing access was a read (`mem_is_read` of that lane was 1).
- R8: A hand-off pulse in state 4 moves to state 5 with no acknowledge. The completion pulse in state 5 moves to state 6, pulses `replay_ld` for a read, and raises `swout_ack` for exactly the first cycle in state 6.
- R9: A hand-off pulse in states 0, 1, 2, 3 or 6 moves to state 6 at the next edge, with `swout_ack` high for the first cycle there. A hand-off pulse in state 5 is an error under R4.
- R10: A completion pulse in state 6 changes nothing and sets no error. A completion pulse in state 0, 1 or 3 sets `ctrl_err`.
- R11: `istall_cycles` increases by one for each cycle spent in state 2. `dstall_cycles` increases by one for each cycle spent in state 4 or 5. Both counters hold at their maximum value.
- R12: A cycle in which every granted lane hits keeps the state at 1 and grants all lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | 1 | Activate pulse |
| susp_req | input | 1 | Suspend, deallocate or halt pulse |
| swout_req | input | 1 | Hand-off pulse |
| fill_done | input | 1 | Completion pulse for the outstanding miss |
| fetch_miss | input | LANES | Per-lane fetch miss for granted lanes |
| mem_miss | input | LANES | Per-lane data-access miss for granted lanes |
| mem_is_read | input | LANES | Per-lane flag, set when the access is a load |
| tick_en | output | LANES | Per-lane tick grant |
| resume_no_fetch | output | 1 | Lane 0 executes the already-fetched instruction |
| replay_ld | output | 1 | Re-run the execute step of the missed load |
| swout_ack | output | 1 | Hand-off acknowledge pulse |
| ctrl_err | output | 1 | Sticky illegal-request flag |
| exec_state | output | 3 | Current state code 0 to 6 |
| istall_cycles | output | CNT_W | Fetch-miss stall cycle count |
| dstall_cycles | output | CNT_W | Data-miss stall cycle count |

## Verification
A wrong state register shows up at the ports within the same cycle. `exec_state` is compared every clock, and the state also decides which lanes `tick_en` grants, so an error appears there too. A lost read flag shows up only on the completion cycle, as a wrong `replay_ld`. A missed hand-off transition shows up one cycle after completion, as a missing `swout_ack`. A stall counter that counts the wrong states drifts by one per cycle, so the stall lengths in the bench are kept short and distinct so that such a drift shows up quickly.

// File: rtl/exec_ctrl_pkg.sv
package exec_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RUN     = 3'd1,
        ST_IMISS   = 3'd2,
        ST_IRESUME = 3'd3,
        ST_DMISS   = 3'd4,
        ST_DSWPEND = 3'd5,
        ST_HANDED  = 3'd6
    } exec_state_e;

    typedef struct packed {
        logic act;
        logic susp;
        logic swout;
        logic fill;
    } exec_evt_t;

    typedef struct packed {
        logic any;
        logic ifetch;
        logic rd;
    } miss_info_t;

    function automatic logic can_tick(exec_state_e s);
        return (s == ST_RUN) || (s == ST_IRESUME);
    endfunction

    function automatic logic dside_wait(exec_state_e s);
        return (s == ST_DMISS) || (s == ST_DSWPEND);
    endfunction

    function automatic logic evt_any(exec_evt_t e);
        return e.act | e.susp | e.swout | e.fill;
    endfunction

endpackage

// File: rtl/exec_lane_scan.sv
module exec_lane_scan
    import exec_ctrl_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             run,
    input  logic             skip_fetch0,
    input  logic [LANES-1:0] fetch_miss,
    input  logic [LANES-1:0] mem_miss,
    input  logic [LANES-1:0] mem_is_read,
    output logic [LANES-1:0] grant,
    output miss_info_t       info
);

    logic [LANES-1:0] fm_eff;

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            if (g == 0) begin : g_first
                assign fm_eff[g] = fetch_miss[g] & ~skip_fetch0;
            end else begin : g_rest
                assign fm_eff[g] = fetch_miss[g];
            end
        end
    endgenerate

    always_comb begin
        logic blocked;
        blocked = 1'b0;
        grant   = '0;
        info    = '0;
        for (int i = 0; i < LANES; i++) begin
            if (run && !blocked) begin
                grant[i] = 1'b1;
                if (fm_eff[i]) begin
                    info.any    = 1'b1;
                    info.ifetch = 1'b1;
                    blocked     = 1'b1;
                end else if (mem_miss[i]) begin
                    info.any = 1'b1;
                    info.rd  = mem_is_read[i];
                    blocked  = 1'b1;
                end
            end
        end
    end

    // A miss can only be reported by a lane that was granted
    always_comb begin
        if (!run) begin
            AST_IDLE_NO_GRANT: assert (grant == '0); // R5
        end
    end

endmodule

// File: rtl/exec_stall_ctr.sv
module exec_stall_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] q
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en && q != CNT_MAX) begin
            q <= q + 1'b1;
        end
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (en && q != CNT_MAX) |=> (q == $past(q) + 1'b1)); // R11
    AST_CTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!en || q == CNT_MAX) |=> $stable(q)); // R11

endmodule

// File: rtl/exec_state_fsm.sv
module exec_state_fsm
    import exec_ctrl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  exec_evt_t   evt,
    input  miss_info_t  miss,
    output exec_state_e state,
    output logic        tick_allow,
    output logic        replay,
    output logic        ack,
    output logic        err
);

    exec_state_e nxt;
    logic        rd_q, rd_n, ack_n, bad;

    assign tick_allow = can_tick(state) && !evt_any(evt);

    always_comb begin
        nxt    = state;
        rd_n   = rd_q;
        ack_n  = 1'b0;
        bad    = 1'b0;
        replay = 1'b0;
        if ($countones(evt) > 1) begin
            bad = 1'b1;
        end else if (evt.act) begin
            if (state == ST_IDLE || state == ST_HANDED) nxt = ST_RUN;
            else bad = 1'b1;
        end else if (evt.susp) begin
            if (state == ST_RUN || state == ST_HANDED) nxt = ST_IDLE;
            else bad = 1'b1;
        end else if (evt.swout) begin
            if (state == ST_DMISS) begin
                nxt = ST_DSWPEND;
            end else if (state == ST_DSWPEND) begin
                bad = 1'b1;
            end else begin
                nxt   = ST_HANDED;
                ack_n = 1'b1;
            end
        end else if (evt.fill) begin
            case (state)
                ST_IMISS: nxt = ST_IRESUME;
                ST_DMISS: begin
                    nxt    = ST_RUN;
                    replay = rd_q;
                end
                ST_DSWPEND: begin
                    nxt    = ST_HANDED;
                    ack_n  = 1'b1;
                    replay = rd_q;
                end
                ST_HANDED: nxt = ST_HANDED;
                default:   bad = 1'b1;
            endcase
        end else if (can_tick(state)) begin
            if (miss.any) begin
                nxt  = miss.ifetch ? ST_IMISS : ST_DMISS;
                rd_n = miss.rd;
            end else begin
                nxt = ST_RUN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            rd_q  <= 1'b0;
            ack   <= 1'b0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            rd_q  <= rd_n;
            ack   <= ack_n;
            err   <= err | bad;
        end
    end

    AST_ACK_IN_HANDED: assert property (@(posedge clk) disable iff (rst)
        ack |-> (state == ST_HANDED)); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R4
    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (evt.act && state == ST_RUN) |=> (state == $past(state))); // R4
    AST_IFILL_RESUME: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IMISS && evt == 4'b0001) |=> (state == ST_IRESUME)); // R6
    AST_PEND_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DMISS && evt == 4'b0010) |=> (!ack && state == ST_DSWPEND)); // R8

endmodule

// File: rtl/core_exec_ctrl.sv
module core_exec_ctrl
    import exec_ctrl_pkg::*;
#(
    parameter int LANES = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             act_req,
    input  logic             susp_req,
    input  logic             swout_req,
    input  logic             fill_done,
    input  logic [LANES-1:0] fetch_miss,
    input  logic [LANES-1:0] mem_miss,
    input  logic [LANES-1:0] mem_is_read,
    output logic [LANES-1:0] tick_en,
    output logic             resume_no_fetch,
    output logic             replay_ld,
    output logic             swout_ack,
    output logic             ctrl_err,
    output logic [2:0]       exec_state,
    output logic [CNT_W-1:0] istall_cycles,
    output logic [CNT_W-1:0] dstall_cycles
);

    exec_evt_t   evt;
    miss_info_t  miss;
    exec_state_e st;
    logic        tick_allow;

    assign evt = '{act: act_req, susp: susp_req, swout: swout_req, fill: fill_done};

    exec_state_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .miss       (miss),
        .state      (st),
        .tick_allow (tick_allow),
        .replay     (replay_ld),
        .ack        (swout_ack),
        .err        (ctrl_err)
    );

    exec_lane_scan #(.LANES(LANES)) u_scan (
        .run         (tick_allow),
        .skip_fetch0 (st == ST_IRESUME),
        .fetch_miss  (fetch_miss),
        .mem_miss    (mem_miss),
        .mem_is_read (mem_is_read),
        .grant       (tick_en),
        .info        (miss)
    );

    exec_stall_ctr #(.CNT_W(CNT_W)) u_ictr (
        .clk (clk),
        .rst (rst),
        .en  (st == ST_IMISS),
        .q   (istall_cycles)
    );

    exec_stall_ctr #(.CNT_W(CNT_W)) u_dctr (
        .clk (clk),
        .rst (rst),
        .en  (dside_wait(st)),
        .q   (dstall_cycles)
    );

    assign exec_state      = st;
    assign resume_no_fetch = (st == ST_IRESUME);

    AST_NO_TICK_STALLED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IMISS || dside_wait(st)) |-> (tick_en == '0)); // R6
    AST_REPLAY_ON_FILL: assert property (@(posedge clk) disable iff (rst)
        replay_ld |-> (fill_done && dside_wait(st))); // R7
    AST_REQ_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (act_req || susp_req || swout_req) |-> (tick_en == '0)); // R3

endmodule

// File: tb/sim_core_exec_ctrl.sv
`timescale 1ns/1ps
module sim_core_exec_ctrl;

    localparam int W  = 4;
    localparam int CW = 4;
    localparam int CMAX = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          act_req = 0, susp_req = 0, swout_req = 0, fill_done = 0;
    logic [W-1:0]  fetch_miss = '0, mem_miss = '0, mem_is_read = '0;
    logic [W-1:0]  tick_en;
    logic          resume_no_fetch, replay_ld, swout_ack, ctrl_err;
    logic [2:0]    exec_state;
    logic [CW-1:0] istall_cycles, dstall_cycles;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_st, m_rd, m_err, m_ack, m_ic, m_dc;

    always #4 clk = ~clk;

    core_exec_ctrl #(.LANES(W), .CNT_W(CW)) u0 (
        .clk, .rst, .act_req, .susp_req, .swout_req, .fill_done,
        .fetch_miss, .mem_miss, .mem_is_read, .tick_en, .resume_no_fetch,
        .replay_ld, .swout_ack, .ctrl_err, .exec_state, .istall_cycles,
        .dstall_cycles
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_rd = 0; m_err = 0; m_ack = 0; m_ic = 0; m_dc = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        act_req = 0; susp_req = 0; swout_req = 0; fill_done = 0;
        fetch_miss = '0; mem_miss = '0; mem_is_read = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    // One cycle: drive, compare against the model, advance the model
    task automatic cyc(string tag, bit a, bit s, bit w, bit f,
                       logic [W-1:0] fm, logic [W-1:0] mm, logic [W-1:0] rd);
        int nev, n_st, n_rd, n_ack, bad, e_rep, stop;
        logic [W-1:0] e_tick;
        @(negedge clk);
        act_req = a; susp_req = s; swout_req = w; fill_done = f;
        fetch_miss = fm; mem_miss = mm; mem_is_read = rd;
        #1;
        nev = int'(a) + int'(s) + int'(w) + int'(f);
        n_st = m_st; n_rd = m_rd; n_ack = 0; bad = 0; e_rep = 0; e_tick = '0;
        if (nev > 1) bad = 1;
        else if (a) begin
            if (m_st == 0 || m_st == 6) n_st = 1; else bad = 1;
        end else if (s) begin
            if (m_st == 1 || m_st == 6) n_st = 0; else bad = 1;
        end else if (w) begin
            if (m_st == 4) n_st = 5;
            else if (m_st == 5) bad = 1;
            else begin n_st = 6; n_ack = 1; end
        end else if (f) begin
            if (m_st == 2) n_st = 3;
            else if (m_st == 4) begin n_st = 1; e_rep = m_rd; end
            else if (m_st == 5) begin n_st = 6; n_ack = 1; e_rep = m_rd; end
            else if (m_st != 6) bad = 1;
        end else if (m_st == 1 || m_st == 3) begin
            stop = 0;
            for (int i = 0; i < W; i++) begin
                if (!stop) begin
                    e_tick[i] = 1'b1;
                    if (fm[i] && !(i == 0 && m_st == 3)) begin
                        n_st = 2; stop = 1;
                    end else if (mm[i]) begin
                        n_st = 4; n_rd = int'(rd[i]); stop = 1;
                    end
                end
            end
            if (!stop) n_st = 1;
        end
        chk(tag, "exec_state", int'(exec_state), m_st);
        chk(tag, "tick_en", int'(tick_en), int'(e_tick));
        chk(tag, "resume_no_fetch", int'(resume_no_fetch), int'(m_st == 3));
        chk(tag, "replay_ld", int'(replay_ld), e_rep);
        chk(tag, "swout_ack", int'(swout_ack), m_ack);
        chk(tag, "ctrl_err", int'(ctrl_err), m_err);
        chk(tag, "istall_cycles", int'(istall_cycles), m_ic);
        chk(tag, "dstall_cycles", int'(dstall_cycles), m_dc);
        if (m_st == 2 && m_ic < CMAX) m_ic++;
        if ((m_st == 4 || m_st == 5) && m_dc < CMAX) m_dc++;
        m_st = n_st; m_rd = n_rd; m_ack = n_ack;
        if (bad) m_err = 1;
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, '0, '0, '0);
    endtask

    initial begin
        model_reset();
        do_reset();
        idle("R1", 2);
        // activation and plain running
        cyc("R2", 1, 0, 0, 0, '0, '0, '0);
        idle("R12", 3);
        // fetch miss in lane 2, lane 3 not granted
        cyc("R5", 0, 0, 0, 0, 4'b0100, 4'b0000, '0);
        idle("R11", 5);
        cyc("R6", 0, 0, 0, 1, '0, '0, '0);
        cyc("R6", 0, 0, 0, 0, 4'b0001, '0, '0);   // lane-0 fetch flag ignored
        idle("R6", 1);
        // read miss in lane 1, fetch miss in lane 3 masked off
        cyc("R7", 0, 0, 0, 0, 4'b1000, 4'b0010, 4'b0010);
        idle("R11", 3);
        cyc("R7", 0, 0, 0, 1, '0, '0, '0);
        idle("R7", 1);
        // fetch and data miss in same lane: fetch wins
        cyc("R6", 0, 0, 0, 0, 4'b0010, 4'b0010, 4'b0010);
        cyc("R6", 0, 0, 0, 1, '0, '0, '0);
        cyc("R6", 0, 0, 0, 0, '0, 4'b0001, 4'b0000);   // write miss from resume
        idle("R7", 2);
        cyc("R7", 0, 0, 0, 1, '0, '0, '0);
        // hand-off while a read miss is outstanding
        idle("R12", 1);
        cyc("R8", 0, 0, 0, 0, '0, 4'b0001, 4'b0001);
        cyc("R8", 0, 0, 1, 0, '0, '0, '0);
        idle("R8", 2);
        cyc("R8", 0, 0, 0, 1, '0, '0, '0);
        idle("R8", 1);
        cyc("R10", 0, 0, 0, 1, '0, '0, '0);
        idle("R10", 1);
        cyc("R2", 1, 0, 0, 0, '0, '0, '0);
        idle("R2", 1);
        cyc("R9", 0, 0, 1, 0, 4'b1111, '0, '0);
        idle("R9", 1);
        cyc("R3", 0, 1, 0, 0, '0, '0, '0);
        idle("R3", 1);
        cyc("R2", 1, 0, 0, 0, '0, '0, '0);
        cyc("R3", 0, 1, 0, 0, '0, '0, '0);
        cyc("R9", 0, 0, 1, 0, '0, '0, '0);   // hand-off from idle
        cyc("R9", 0, 0, 1, 0, '0, '0, '0);   // and again while handed off
        cyc("R2", 1, 0, 0, 0, '0, '0, '0);
        cyc("R9", 0, 0, 0, 0, 4'b0001, '0, '0);
        cyc("R9", 0, 0, 1, 0, '0, '0, '0);   // hand-off during fetch stall
        idle("R9", 2);
        // counter saturation
        do_reset();
        cyc("R2", 1, 0, 0, 0, '0, '0, '0);
        cyc("R11", 0, 0, 0, 0, 4'b0001, '0, '0);
        idle("R11", 20);
        cyc("R11", 0, 0, 0, 1, '0, '0, '0);
        idle("R11", 2);
        // illegal requests
        cyc("R4", 1, 0, 0, 0, '0, '0, '0);
        idle("R4", 3);
        do_reset();
        cyc("R10", 0, 0, 0, 1, '0, '0, '0);
        idle("R10", 2);
        do_reset();
        cyc("R4", 1, 0, 1, 0, '0, '0, '0);
        idle("R4", 2);
        do_reset();
        cyc("R2", 1, 0, 0, 0, '0, '0, '0);
        cyc("R7", 0, 0, 0, 0, '0, 4'b0001, 4'b0001);
        cyc("R8", 0, 0, 1, 0, '0, '0, '0);
        cyc("R9", 0, 0, 1, 0, '0, '0, '0);   // second hand-off while pending
        cyc("R3", 0, 1, 0, 0, '0, '0, '0);   // suspend while pending
        cyc("R8", 0, 0, 0, 1, '0, '0, '0);
        idle("R4", 2);
        // mixed traffic
        for (int k = 0; k < 4; k++) begin
            do_reset();
            for (int j = 0; j < 150; j++) begin
                int r;
                r = int'($urandom_range(0, 31));
                cyc("R5", r == 0, r == 1, r == 2, r == 3 || r == 4,
                    ($urandom_range(0, 5) == 0) ? W'($urandom) : '0,
                    ($urandom_range(0, 4) == 0) ? W'($urandom) : '0,
                    W'($urandom));
            end
        end
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule